// File: doc/BRIEF.md
# Start-Time Fair Queuing Rank Calculator

This block assigns a scheduling rank to each arriving packet under start-time fair queuing. An upstream stage presents a flow number, the packet length, the current virtual time and a valid strobe. The block keeps the finish tag of every flow in a register table. The start tag is the larger of the stored finish tag and the virtual time. The block returns the start tag as the rank and advances the flow's finish tag by the packet length. A downstream sorter orders packets by this rank. Producing the virtual time and classifying packets into flows happen elsewhere.

The block accepts one packet in every cycle. A parameter picks the pipeline variant. With `PIPE = 0` the table read, the arithmetic and the table write all sit in one cycle, and the rank appears one cycle after the input. With `PIPE = 1` the table read is registered first and the arithmetic happens in a second stage, so the rank appears two cycles after the input. In that variant, a packet that reads a flow while the flow's previous packet is still in the second stage takes the updated finish tag from a forwarding path, not from the table.

Top module: `sfq_rank_calc`

## Requirements
- R1: A synchronous active-high reset clears every flow's finish tag to zero and drives `valid_o` low, so the first packet of any flow after reset gets a rank equal to its `vtime_i`.
- R2: `valid_o` is high in exactly the cycle that falls 1 + `PIPE` clock edges after a cycle with `valid_i` high, and a new packet can be presented in every cycle.
- R3: The rank equals the unsigned maximum of the flow's stored finish tag and `vtime_i` sampled with the packet.
- R4: After a packet is handled, its flow's finish tag equals that packet's rank plus `len_i`, with `len_i` zero-extended to the tag width.
- R5: Packets of the same flow in consecutive cycles each see the finish tag left by the packet just before them, in both pipeline variants.
- R6: A packet changes only the finish tag of its own flow. Packets interleaved across flows do not affect one another's ranks.
- R7: In cycles with `valid_i` low, no finish tag changes and `valid_o` stays low, whatever values the other inputs carry.
- R8: Comparisons are unsigned: a virtual time with its most significant bit set counts as larger than any smaller finish tag.
- R9: A zero-length packet leaves its flow's finish tag equal to its own rank.
- R10: Both values of `PIPE` return the same rank sequence for the same input sequence. Only the latency differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Packet present this cycle |
| flow_i | input | $clog2(FLOWS) | Flow number of the packet |
| len_i | input | LW | Packet length |
| vtime_i | input | TW | Current virtual time |
| valid_o | output | 1 | Rank valid |
| rank_o | output | TW | Start tag of the packet, used as its rank |

## Verification
The bench builds two copies side by side with 16 flows, 32-bit tags and 16-bit lengths, one with `PIPE = 1` and one with `PIPE = 0`, and drives both with the same stimulus. The registered-read copy exposes the forwarding path to back-to-back packets of one flow. The single-cycle copy shows that both variants produce the same ranks at their own latencies. The 32-bit tags make it possible to test unsigned comparison with a virtual time whose top bit is set, and 16 flows are enough to interleave several flows and still leave some untouched.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

   // Unsigned maximum of two tags of equal width.
   function automatic logic [63:0] sfq_umax(input logic [63:0] a, input logic [63:0] b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sfq_finish_table.sv
module sfq_finish_table #(
   parameter int FLOWS = 16,
   parameter int TW    = 32,
   localparam int FW   = $clog2(FLOWS)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          we_i,
   input  logic [FW-1:0] waddr_i,
   input  logic [TW-1:0] wdata_i,
   input  logic [FW-1:0] raddr_i,
   output logic [TW-1:0] rdata_o
);

   logic [TW-1:0] fin_q [FLOWS];

   for (genvar g = 0; g < FLOWS; g++) begin : g_entry
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            fin_q[g] <= '0;
         end else if (we_i && (waddr_i == FW'(g))) begin
            fin_q[g] <= wdata_i;
         end
      end
   end

   assign rdata_o = fin_q[raddr_i];

endmodule

// File: rtl/sfq_tag_math.sv
module sfq_tag_math
   import sfq_pkg::*;
#(
   parameter int TW = 32,
   parameter int LW = 16
) (
   input  logic [TW-1:0] prev_fin_i,
   input  logic [TW-1:0] vtime_i,
   input  logic [LW-1:0] len_i,
   output logic [TW-1:0] start_o,
   output logic [TW-1:0] finish_o
);

   logic [63:0] wide_max;

   always_comb begin
      wide_max = sfq_umax(64'(prev_fin_i), 64'(vtime_i));
      start_o  = wide_max[TW-1:0];
      finish_o = start_o + TW'(len_i);
   end

endmodule

// File: rtl/sfq_fwd_sel.sv
module sfq_fwd_sel #(
   parameter int FLOWS = 16,
   parameter int TW    = 32,
   localparam int FW   = $clog2(FLOWS)
) (
   input  logic          pend_v_i,
   input  logic [FW-1:0] pend_flow_i,
   input  logic [TW-1:0] pend_fin_i,
   input  logic [FW-1:0] req_flow_i,
   input  logic [TW-1:0] table_fin_i,
   output logic [TW-1:0] fin_o
);

   logic hit;

   always_comb begin
      hit   = pend_v_i && (pend_flow_i == req_flow_i);
      fin_o = hit ? pend_fin_i : table_fin_i;
   end

endmodule

// File: rtl/sfq_rank_calc.sv
module sfq_rank_calc #(
   parameter int FLOWS = 16,
   parameter int TW    = 32,
   parameter int LW    = 16,
   parameter int PIPE  = 0,
   localparam int FW   = $clog2(FLOWS)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          valid_i,
   input  logic [FW-1:0] flow_i,
   input  logic [LW-1:0] len_i,
   input  logic [TW-1:0] vtime_i,
   output logic          valid_o,
   output logic [TW-1:0] rank_o
);

   initial begin
      if (FLOWS < 2 || (1 << FW) != FLOWS) $error("FLOWS must be a power of two, at least 2");
      if (LW > TW)                           $error("LW must not exceed TW");
      if (TW > 64)                           $error("TW must not exceed 64");
      if (PIPE != 0 && PIPE != 1)            $error("PIPE must be 0 or 1");
   end

   logic          wr_en;
   logic [FW-1:0] wr_addr;
   logic [TW-1:0] wr_data;
   logic [TW-1:0] rd_data;

   sfq_finish_table #(.FLOWS(FLOWS), .TW(TW)) u_table (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (wr_en),
      .waddr_i (wr_addr),
      .wdata_i (wr_data),
      .raddr_i (flow_i),
      .rdata_o (rd_data)
   );

   if (PIPE == 0) begin : g_single
      logic [TW-1:0] start_tag;
      logic [TW-1:0] finish_tag;

      sfq_tag_math #(.TW(TW), .LW(LW)) u_math (
         .prev_fin_i (rd_data),
         .vtime_i    (vtime_i),
         .len_i      (len_i),
         .start_o    (start_tag),
         .finish_o   (finish_tag)
      );

      assign wr_en   = valid_i;
      assign wr_addr = flow_i;
      assign wr_data = finish_tag;

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            valid_o <= 1'b0;
            rank_o  <= '0;
         end else begin
            valid_o <= valid_i;
            if (valid_i) rank_o <= start_tag;
         end
      end
   end else begin : g_staged
      logic          s1_v;
      logic [FW-1:0] s1_flow;
      logic [LW-1:0] s1_len;
      logic [TW-1:0] s1_vt;
      logic [TW-1:0] s1_fin;
      logic [TW-1:0] start_tag;
      logic [TW-1:0] finish_tag;
      logic [TW-1:0] fresh_fin;

      sfq_fwd_sel #(.FLOWS(FLOWS), .TW(TW)) u_fwd (
         .pend_v_i    (s1_v),
         .pend_flow_i (s1_flow),
         .pend_fin_i  (finish_tag),
         .req_flow_i  (flow_i),
         .table_fin_i (rd_data),
         .fin_o       (fresh_fin)
      );

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            s1_v    <= 1'b0;
            s1_flow <= '0;
            s1_len  <= '0;
            s1_vt   <= '0;
            s1_fin  <= '0;
         end else begin
            s1_v <= valid_i;
            if (valid_i) begin
               s1_flow <= flow_i;
               s1_len  <= len_i;
               s1_vt   <= vtime_i;
               s1_fin  <= fresh_fin;
            end
         end
      end

      sfq_tag_math #(.TW(TW), .LW(LW)) u_math (
         .prev_fin_i (s1_fin),
         .vtime_i    (s1_vt),
         .len_i      (s1_len),
         .start_o    (start_tag),
         .finish_o   (finish_tag)
      );

      assign wr_en   = s1_v;
      assign wr_addr = s1_flow;
      assign wr_data = finish_tag;

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            valid_o <= 1'b0;
            rank_o  <= '0;
         end else begin
            valid_o <= s1_v;
            if (s1_v) rank_o <= start_tag;
         end
      end
   end

endmodule

// File: rtl/sfq_rank_calc_chk.sv
module sfq_rank_calc_chk #(
   parameter int FLOWS = 16,
   parameter int TW    = 32,
   parameter int LW    = 16,
   parameter int PIPE  = 0,
   localparam int FW   = $clog2(FLOWS),
   localparam int LAT  = 1 + PIPE
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          valid_i,
   input logic [FW-1:0] flow_i,
   input logic [LW-1:0] len_i,
   input logic [TW-1:0] vtime_i,
   input logic          valid_o,
   input logic [TW-1:0] rank_o
);

   logic          dv  [LAT];
   logic [FW-1:0] dfl [LAT];
   logic [LW-1:0] dln [LAT];
   logic [TW-1:0] dvt [LAT];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dv[0] <= 1'b0;
      end else begin
         dv[0] <= valid_i;
      end
      dfl[0] <= flow_i;
      dln[0] <= len_i;
      dvt[0] <= vtime_i;
   end

   for (genvar k = 1; k < LAT; k++) begin : g_delay
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            dv[k] <= 1'b0;
         end else begin
            dv[k] <= dv[k-1];
         end
         dfl[k] <= dfl[k-1];
         dln[k] <= dln[k-1];
         dvt[k] <= dvt[k-1];
      end
   end

   // Most recent output, used to check same-flow ordering.
   logic          pv;
   logic [FW-1:0] pfl;
   logic [TW-1:0] prk;
   logic [LW-1:0] pln;
   logic          rst_q;

   always_ff @(posedge clk_i) begin
      rst_q <= rst_i;
      if (rst_i) begin
         pv <= 1'b0;
      end else if (valid_o) begin
         pv  <= 1'b1;
         pfl <= dfl[LAT-1];
         prk <= rank_o;
         pln <= dln[LAT-1];
      end
   end

   p_lat_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o == dv[LAT-1]);

   p_rank_floor_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> rank_o >= dvt[LAT-1]);

   p_same_flow_order_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && pv && dfl[LAT-1] == pfl) |-> rank_o >= prk + TW'(pln));

   always @(negedge clk_i) begin
      if (rst_q) begin
         p_reset_idle_r1: assert (!valid_o);
      end
   end

endmodule

bind sfq_rank_calc sfq_rank_calc_chk #(
   .FLOWS (FLOWS),
   .TW    (TW),
   .LW    (LW),
   .PIPE  (PIPE)
) u_chk (.*);

// File: tb/sfq_rank_calc_tb_top.sv
`timescale 1ns/1ps
module sfq_rank_calc_tb_top;

   localparam int FLOWS = 16;
   localparam int TW    = 32;
   localparam int LW    = 16;
   localparam int FW    = $clog2(FLOWS);

   logic          clk = 1'b0;
   logic          rst_i;
   logic          valid_i;
   logic [FW-1:0] flow_i;
   logic [LW-1:0] len_i;
   logic [TW-1:0] vtime_i;
   logic          va_o, vb_o;
   logic [TW-1:0] ra_o, rb_o;

   always #2 clk = ~clk;

   sfq_rank_calc #(.FLOWS(FLOWS), .TW(TW), .LW(LW), .PIPE(1)) dut_i (
      .clk_i (clk), .rst_i (rst_i), .valid_i (valid_i), .flow_i (flow_i),
      .len_i (len_i), .vtime_i (vtime_i), .valid_o (va_o), .rank_o (ra_o)
   );

   sfq_rank_calc #(.FLOWS(FLOWS), .TW(TW), .LW(LW), .PIPE(0)) dut_b_i (
      .clk_i (clk), .rst_i (rst_i), .valid_i (valid_i), .flow_i (flow_i),
      .len_i (len_i), .vtime_i (vtime_i), .valid_o (vb_o), .rank_o (rb_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   logic [TW-1:0] mfin [FLOWS];
   logic [TW-1:0] qa_rank[$], qb_rank[$];
   int            qa_cyc[$],  qb_cyc[$];
   string         qa_tag[$],  qb_tag[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [TW-1:0] act,
                        input logic [TW-1:0] exp, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Output monitor: ranks against the model, arrival cycle against latency (R2, R10).
   always @(negedge clk) begin
      if (!rst_i && !done) begin
         if (va_o) begin
            if (qa_rank.size() == 0) begin
               check(1'b0, "R2", 1, 0, "pipelined copy: unexpected valid_o");
            end else begin
               check(ra_o == qa_rank[0], qa_tag[0], ra_o, qa_rank[0], "pipelined copy rank");
               check(cyc == qa_cyc[0], "R2", cyc, qa_cyc[0], "pipelined copy arrival cycle");
               void'(qa_rank.pop_front()); void'(qa_cyc.pop_front()); void'(qa_tag.pop_front());
            end
         end
         if (vb_o) begin
            if (qb_rank.size() == 0) begin
               check(1'b0, "R10", 1, 0, "single-cycle copy: unexpected valid_o");
            end else begin
               check(rb_o == qb_rank[0], qb_tag[0], rb_o, qb_rank[0], "single-cycle copy rank (R10)");
               check(cyc == qb_cyc[0], "R2", cyc, qb_cyc[0], "single-cycle copy arrival cycle");
               void'(qb_rank.pop_front()); void'(qb_cyc.pop_front()); void'(qb_tag.pop_front());
            end
         end
      end
   end

   task automatic send(input int f, input int unsigned ln, input logic [TW-1:0] vt, input string tag);
      logic [TW-1:0] st;
      @(negedge clk);
      valid_i = 1'b1;
      flow_i  = FW'(f);
      len_i   = LW'(ln);
      vtime_i = vt;
      st = (mfin[f] > vt) ? mfin[f] : vt;
      mfin[f] = st + TW'(LW'(ln));
      qa_rank.push_back(st); qa_cyc.push_back(cyc + 2); qa_tag.push_back(tag);
      qb_rank.push_back(st); qb_cyc.push_back(cyc + 1); qb_tag.push_back(tag);
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         valid_i = 1'b0;
         flow_i  = FW'(i * 7 + 3);
         len_i   = LW'(16'hBEEF + i);
         vtime_i = 32'hFFFF_0000 + TW'(i);
      end
   endtask

   task automatic drain(input string tag);
      quiet(4);
      check(qa_rank.size() == 0 && qb_rank.size() == 0, tag,
            TW'(qa_rank.size() + qb_rank.size()), 0, "outputs outstanding after drain");
   endtask

   task automatic t_reset;
      valid_i = 1'b0; flow_i = '0; len_i = '0; vtime_i = '0;
      rst_i = 1'b1;
      for (int f = 0; f < FLOWS; f++) mfin[f] = '0;
      repeat (3) @(negedge clk);
      check(!va_o && !vb_o, "R1", {va_o, vb_o}, 0, "valid_o during reset");
      rst_i = 1'b0;
      @(negedge clk);
      check(!va_o && !vb_o, "R1", {va_o, vb_o}, 0, "valid_o after reset");
   endtask

   task automatic t_first_packets;   // R1, R3
      for (int f = 0; f < 4; f++) send(f, 10 + f, 32'd100, "R1");
      drain("R1");
   endtask

   task automatic t_back_to_back;    // R5, R4
      send(6, 40, 32'd0, "R5");
      send(6, 25, 32'd0, "R5");
      send(6, 7,  32'd10, "R5");
      send(6, 3,  32'd0, "R4");
      drain("R5");
   endtask

   task automatic t_interleave;      // R6
      for (int i = 0; i < 6; i++) send((i % 2 == 0) ? 8 : 9, 5 * (i + 1), 32'd50, "R6");
      send(10, 1, 32'd50, "R6");
      drain("R6");
   endtask

   task automatic t_vtime_wins;      // R3
      send(6, 2, 32'd5000, "R3");
      send(0, 4, 32'd20, "R3");
      drain("R3");
   endtask

   task automatic t_idle_inputs;     // R7
      quiet(6);
      check(!va_o && !vb_o, "R7", {va_o, vb_o}, 0, "valid_o with valid_i low");
      send(8, 1, 32'd0, "R7");
      send(9, 1, 32'd0, "R7");
      drain("R7");
   endtask

   task automatic t_unsigned;        // R8
      send(5, 9, 32'h8000_0000, "R8");
      send(5, 1, 32'd1, "R8");
      send(11, 2, 32'hF000_0000, "R8");
      drain("R8");
   endtask

   task automatic t_zero_len;        // R9
      send(12, 0, 32'd300, "R9");
      send(12, 0, 32'd200, "R9");
      send(12, 5, 32'd100, "R9");
      send(12, 0, 32'd0, "R9");
      drain("R9");
   endtask

   initial begin
      rst_i = 1'b1;
      t_reset();
      t_first_packets();
      t_back_to_back();
      t_interleave();
      t_vtime_wins();
      t_idle_inputs();
      t_unsigned();
      t_zero_len();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule